// File: doc/BRIEF.md
# EPROM Byte Burn Sequencer

This block sits on the programmer side of an on-chip EPROM and writes one byte per request. A request names a target (the code array, the encryption array or one of three lock bits) together with a 14-bit address and an 8-bit byte. The block latches them, presents them on its address, data and mode-select outputs, and waits out the address setup time. It then switches on the high programming voltage and fires a burst of active-low program pulses. The burst has 5 pulses for a code byte and 25 for any other target. At the end it switches the voltage off again and reports completion.

All intervals are counted in reference-clock cycles. Millisecond intervals derive from a clocks-per-millisecond parameter, and the address setup and hold windows are given in oscillator periods. The high-voltage switch is represented by a single enable output. An abort input drops that enable and releases the program line at once. The sequencer then lets the voltage decay for the hold time before it returns to idle.

Top module: `eprom_burn_seq`

## Requirements
- R1: After reset, busy, done and vpp_en are 0, prog_n is 1, and addr_out, data_out and mode_ctl are all zero.
- R2: A request is taken only when req is high in idle with a target code of 0 (code), 1 (encryption), 2 (lock 1), 3 (lock 2) or 4 (lock 3). busy is high from the next cycle. Codes 5 to 7 and requests made while busy have no effect.
- R3: mode_ctl[4:0] takes these values per target: code 01111, encryption 01101, lock 1 11111, lock 2 11100, lock 3 10110.
- R4: addr_out, data_out and mode_ctl take the request's values at acceptance and stay unchanged until the next acceptance. They are valid for SETUP_CYC cycles before vpp_en rises.
- R5: vpp_en is high for VPP_SETUP_MS*CLK_PER_MS cycles before prog_n first goes low.
- R6: A code target gets exactly CODE_PULSES (5) low pulses. Every other target gets AUX_PULSES (25).
- R7: Each program pulse holds prog_n low for PULSE_MS*CLK_PER_MS cycles (100 ms by default).
- R8: Between consecutive pulses, prog_n is high for GAP_MS*CLK_PER_MS cycles while vpp_en stays high.
- R9: After the last pulse rises, vpp_en stays high for the larger of VPP_HOLD_MS*CLK_PER_MS and HOLD_CYC cycles. prog_n is low only while vpp_en is high.
- R10: done is high for exactly one cycle: the first cycle in which vpp_en is low after the hold. busy is low in the following cycle.
- R11: If abort is high during a sequence, vpp_en goes low and prog_n goes high in that same cycle. No done follows. busy stays high for VPP_HOLD_MS*CLK_PER_MS more cycles and then falls. An abort in idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Start a byte burn (sampled in idle) |
| target | input | 3 | Target code, see R2 |
| addr_in | input | 14 | Byte address |
| data_in | input | 8 | Byte value |
| abort | input | 1 | Cancel the running sequence |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| addr_out | output | 14 | Address presented to the EPROM |
| data_out | output | 8 | Data presented to the EPROM |
| mode_ctl | output | 5 | Mode-select lines, see R3 |
| vpp_en | output | 1 | High programming voltage enable |
| prog_n | output | 1 | Active-low program pulse |

## Verification
The bench shortens the millisecond base so that the 48-cycle hold exceeds the scaled voltage hold. A design that ignored the maximum would then drop the voltage early. A pulse counter that was off by one, or that took its length from the wrong target, shows up as 4, 6 or 24 pulses. A request made halfway through a burn would corrupt the presented address if acceptance were not limited to idle. For aborts, the bench checks within the same cycle that the voltage and program line release, and it times the decay window. An abort that waited for the next edge, or that still produced done, would be caught.

// File: rtl/eprom_burn_pkg.sv
package eprom_burn_pkg;

  typedef enum logic [2:0] {
    TGT_CODE  = 3'd0,
    TGT_CRYPT = 3'd1,
    TGT_LOCK1 = 3'd2,
    TGT_LOCK2 = 3'd3,
    TGT_LOCK3 = 3'd4
  } burn_tgt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_VRISE,
    ST_PULSE,
    ST_GAP,
    ST_VHOLD,
    ST_DONE,
    ST_ABORT
  } burn_st_e;

  function automatic logic tgt_valid(input logic [2:0] t);
    return t <= 3'd4;
  endfunction

  // mode line pattern, bit 4 first: row select, column select, strobe,
  // array select, lock select
  function automatic logic [4:0] mode_pattern(input logic [2:0] t);
    case (t)
      3'd0:    return 5'b01111;
      3'd1:    return 5'b01101;
      3'd2:    return 5'b11111;
      3'd3:    return 5'b11100;
      3'd4:    return 5'b10110;
      default: return 5'b01111;
    endcase
  endfunction

  function automatic int unsigned ms_cycles(input int unsigned ms, input int unsigned cpm);
    return ms * cpm;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned pulses_for(input logic [2:0] t, input int unsigned code_n,
                                             input int unsigned aux_n);
    return (t == 3'd0) ? code_n : aux_n;
  endfunction

endpackage

// File: rtl/burn_req_latch.sv
module burn_req_latch
  import eprom_burn_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [2:0]        tgt,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [MODE_W-1:0] mode_q
);

  logic [4:0] pattern;
  assign pattern = mode_pattern(tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  // one flop per mode line
  for (genvar i = 0; i < MODE_W; i++) begin : g_mode
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    mode_q[i] <= 1'b0;
      else if (load) mode_q[i] <= pattern[i];
    end
  end

endmodule

// File: rtl/burn_timer.sv
module burn_timer #(
  parameter int unsigned TW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/burn_pulse_cnt.sv
module burn_pulse_cnt #(
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  input  logic          dec,
  output logic          last
);

  logic [PW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  left <= '0;
    else if (load)               left <= load_val;
    else if (dec && left != '0)  left <= left - 1'b1;
  end

  assign last = (left == PW'(1));

endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
  import eprom_burn_pkg::*;
#(
  parameter int unsigned ADDR_W       = 14,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_PER_MS   = 5000,
  parameter int unsigned SETUP_CYC    = 48,
  parameter int unsigned HOLD_CYC     = 48,
  parameter int unsigned VPP_SETUP_MS = 10,
  parameter int unsigned VPP_HOLD_MS  = 10,
  parameter int unsigned PULSE_MS     = 100,
  parameter int unsigned GAP_MS       = 10,
  parameter int unsigned CODE_PULSES  = 5,
  parameter int unsigned AUX_PULSES   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [2:0]        target,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              abort,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out,
  output logic [4:0]        mode_ctl,
  output logic              vpp_en,
  output logic              prog_n
);

  localparam int unsigned SETUP_D = SETUP_CYC;
  localparam int unsigned VRISE_D = ms_cycles(VPP_SETUP_MS, CLK_PER_MS);
  localparam int unsigned PULSE_D = ms_cycles(PULSE_MS, CLK_PER_MS);
  localparam int unsigned GAP_D   = ms_cycles(GAP_MS, CLK_PER_MS);
  localparam int unsigned ABORT_D = ms_cycles(VPP_HOLD_MS, CLK_PER_MS);
  localparam int unsigned HOLD_D  = max_u(ABORT_D, HOLD_CYC);
  localparam int unsigned MAX_D   = max_u(max_u(max_u(SETUP_D, VRISE_D), max_u(PULSE_D, GAP_D)),
                                          HOLD_D);
  localparam int unsigned TW      = $clog2(MAX_D + 1);
  localparam int unsigned PW      = $clog2(max_u(CODE_PULSES, AUX_PULSES) + 1);

  burn_st_e st, st_nxt;

  // named internal events
  logic          accept;
  logic          abort_hit;
  logic          tmr_exp;
  logic          last_pulse;
  logic          tmr_ld;
  logic [TW-1:0] tmr_val;
  logic          pc_dec;
  logic          hv_phase;

  assign accept    = req && (st == ST_IDLE) && tgt_valid(target);
  assign hv_phase  = st inside {ST_VRISE, ST_PULSE, ST_GAP, ST_VHOLD};
  assign abort_hit = abort && (hv_phase || st == ST_SETUP);

  burn_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(5)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .addr_in (addr_in),
    .data_in (data_in),
    .tgt     (target),
    .addr_q  (addr_out),
    .data_q  (data_out),
    .mode_q  (mode_ctl)
  );

  burn_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  burn_pulse_cnt #(.PW(PW)) u_pcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (PW'(pulses_for(target, CODE_PULSES, AUX_PULSES))),
    .dec      (pc_dec),
    .last     (last_pulse)
  );

  always_comb begin
    st_nxt  = st;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    pc_dec  = 1'b0;
    case (st)
      ST_IDLE: if (accept) begin
        st_nxt = ST_SETUP; tmr_ld = 1'b1; tmr_val = TW'(SETUP_D - 1);
      end
      ST_SETUP: if (tmr_exp) begin
        st_nxt = ST_VRISE; tmr_ld = 1'b1; tmr_val = TW'(VRISE_D - 1);
      end
      ST_VRISE: if (tmr_exp) begin
        st_nxt = ST_PULSE; tmr_ld = 1'b1; tmr_val = TW'(PULSE_D - 1);
      end
      ST_PULSE: if (tmr_exp) begin
        pc_dec = 1'b1;
        tmr_ld = 1'b1;
        if (last_pulse) begin
          st_nxt = ST_VHOLD; tmr_val = TW'(HOLD_D - 1);
        end else begin
          st_nxt = ST_GAP;   tmr_val = TW'(GAP_D - 1);
        end
      end
      ST_GAP: if (tmr_exp) begin
        st_nxt = ST_PULSE; tmr_ld = 1'b1; tmr_val = TW'(PULSE_D - 1);
      end
      ST_VHOLD: if (tmr_exp) st_nxt = ST_DONE;
      ST_DONE:  st_nxt = ST_IDLE;
      ST_ABORT: if (tmr_exp) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
    if (abort_hit) begin
      st_nxt  = ST_ABORT;
      tmr_ld  = 1'b1;
      tmr_val = TW'(ABORT_D - 1);
      pc_dec  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  assign busy   = (st != ST_IDLE);
  assign done   = (st == ST_DONE);
  assign vpp_en = hv_phase && !abort;
  assign prog_n = !((st == ST_PULSE) && !abort);

endmodule

// File: rtl/eprom_burn_chk.sv
module eprom_burn_chk #(
  parameter int unsigned ADDR_W    = 14,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PULSE_CYC = 500000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [2:0]        target,
  input logic              abort,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] addr_out,
  input logic [DATA_W-1:0] data_out,
  input logic [4:0]        mode_ctl,
  input logic              vpp_en,
  input logic              prog_n
);

  logic [31:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_cnt <= '0;
    else if (!prog_n) lo_cnt <= lo_cnt + 1;
    else              lo_cnt <= '0;
  end

  assert_bad_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy && target > 3'd4) |=> !busy);

  assert_held_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(addr_out) && $stable(data_out) && $stable(mode_ctl)));

  assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(prog_n) && !abort) |-> (lo_cnt == PULSE_CYC));

  assert_vpp_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vpp_en |-> busy);

  assert_low_needs_vpp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> vpp_en);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_abort_decay_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vpp_en) && abort) |=> (busy && !vpp_en && !done));

endmodule

bind eprom_burn_seq eprom_burn_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PULSE_CYC (PULSE_MS * CLK_PER_MS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .target   (target),
  .abort    (abort),
  .busy     (busy),
  .done     (done),
  .addr_out (addr_out),
  .data_out (data_out),
  .mode_ctl (mode_ctl),
  .vpp_en   (vpp_en),
  .prog_n   (prog_n)
);

// File: tb/tb_eprom_burn_seq.sv
module tb_eprom_burn_seq;

  localparam int C     = 4;
  localparam int SETUP = 48;
  localparam int HOLDC = 48;
  localparam int VRISE = 10 * C;
  localparam int PLO   = 100 * C;
  localparam int GAP   = 10 * C;
  localparam int VHOLD = (10 * C > HOLDC) ? 10 * C : HOLDC;
  localparam int ADEC  = 10 * C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  target = 3'd0;
  logic [13:0] addr_in = '0;
  logic [7:0]  data_in = '0;
  logic        abort = 1'b0;
  logic        busy, done, vpp_en, prog_n;
  logic [13:0] addr_out;
  logic [7:0]  data_out;
  logic [4:0]  mode_ctl;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  eprom_burn_seq #(.CLK_PER_MS(C)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .target(target), .addr_in(addr_in),
    .data_in(data_in), .abort(abort), .busy(busy), .done(done), .addr_out(addr_out),
    .data_out(data_out), .mode_ctl(mode_ctl), .vpp_en(vpp_en), .prog_n(prog_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && vpp_en == 0, "R1 status", {busy, done, vpp_en}, 0);
    check(prog_n == 1, "R1 prog_n", prog_n, 1);
    check(addr_out == 0 && data_out == 0 && mode_ctl == 0, "R1 outputs",
          int'(addr_out) + int'(data_out) + int'(mode_ctl), 0);
  endtask

  task automatic run_burn(input logic [2:0] tgt, input logic [13:0] a, input logic [7:0] d,
                          input logic [4:0] exp_mode, input int exp_pulses, input bit poke);
    int n = 0, setup_c = 0, pre_c = 0, pulses = 0, lo_run = 0, hi_run = 0;
    int lo_min = 1 << 30, lo_max = 0, gap_min = 1 << 30, gap_max = 0;
    bit vpp_seen = 0, any_low = 0, stable_ok = 1, bad_low = 0, got_done = 0;
    @(negedge clk);
    req = 1; target = tgt; addr_in = a; data_in = d;
    @(negedge clk);
    req = 0; addr_in = ~a; data_in = ~d;
    check(busy == 1, "R2 busy after accept", busy, 1);
    while (n < 20000) begin
      if (done) begin
        got_done = 1;
        break;
      end
      if (addr_out != a || data_out != d || mode_ctl != exp_mode) stable_ok = 0;
      if (!prog_n && !vpp_en) bad_low = 1;
      if (!vpp_seen) begin
        if (vpp_en) vpp_seen = 1; else setup_c++;
      end
      if (vpp_en && !any_low && prog_n) pre_c++;
      if (!prog_n) begin
        if (any_low && hi_run > 0) begin
          if (hi_run < gap_min) gap_min = hi_run;
          if (hi_run > gap_max) gap_max = hi_run;
        end
        hi_run = 0;
        any_low = 1;
        lo_run++;
      end else begin
        if (lo_run > 0) begin
          pulses++;
          if (lo_run < lo_min) lo_min = lo_run;
          if (lo_run > lo_max) lo_max = lo_run;
          lo_run = 0;
        end
        if (any_low && vpp_en) hi_run++;
      end
      n++;
      if (poke && n == 20) begin
        req = 1; target = 3'd1;
      end else if (poke && n == 21) begin
        req = 0; target = tgt;
      end
      @(negedge clk);
    end
    check(got_done, "R10 done seen", got_done, 1);
    check(vpp_en == 0, "R10 vpp low at done", vpp_en, 0);
    check(stable_ok, "R4 R3 addr/data/mode held", stable_ok, 1);
    check(mode_ctl == exp_mode, "R3 mode pattern", mode_ctl, exp_mode);
    check(setup_c == SETUP, "R4 setup before vpp", setup_c, SETUP);
    check(pre_c == VRISE, "R5 vpp before first pulse", pre_c, VRISE);
    check(pulses == exp_pulses, "R6 pulse count", pulses, exp_pulses);
    check(lo_min == PLO && lo_max == PLO, "R7 pulse width", lo_max, PLO);
    if (exp_pulses > 1)
      check(gap_min == GAP && gap_max == GAP, "R8 gap width", gap_max, GAP);
    check(hi_run == VHOLD, "R9 vpp hold after last", hi_run, VHOLD);
    check(!bad_low, "R9 pulse without vpp", bad_low, 0);
    @(negedge clk);
    check(busy == 0 && done == 0, "R10 idle after done", {busy, done}, 0);
  endtask

  task automatic t_bad_target();
    for (int t = 5; t < 8; t++) begin
      @(negedge clk);
      req = 1; target = 3'(t); addr_in = 14'h1234; data_in = 8'h77;
      @(negedge clk);
      req = 0;
      check(busy == 0 && vpp_en == 0, "R2 invalid target ignored", busy, 0);
    end
  endtask

  task automatic t_abort();
    int cnt = 0;
    bit clean = 1;
    @(negedge clk);
    abort = 1;
    @(negedge clk);
    abort = 0;
    check(busy == 0 && vpp_en == 0, "R11 idle abort ignored", busy, 0);
    req = 1; target = 3'd0; addr_in = 14'h0abc; data_in = 8'h3c;
    @(negedge clk);
    req = 0;
    while (prog_n && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
    repeat (10) @(negedge clk);
    abort = 1;
    #1;
    check(vpp_en == 0 && prog_n == 1, "R11 immediate release", {vpp_en, prog_n}, 1);
    @(negedge clk);
    abort = 0;
    cnt = 0;
    while (busy && cnt < 1000) begin
      if (vpp_en || done || !prog_n) clean = 0;
      cnt++;
      @(negedge clk);
    end
    check(clean, "R11 no vpp/done during decay", clean, 1);
    check(cnt == ADEC, "R11 decay length", cnt, ADEC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_bad_target();
    run_burn(3'd0, 14'h2a5c, 8'hc3, 5'b01111, 5, 1'b0);
    run_burn(3'd0, 14'h0155, 8'h5a, 5'b01111, 5, 1'b1);
    run_burn(3'd1, 14'h003f, 8'h81, 5'b01101, 25, 1'b0);
    run_burn(3'd2, 14'h0000, 8'hff, 5'b11111, 25, 1'b0);
    run_burn(3'd3, 14'h3fff, 8'h00, 5'b11100, 25, 1'b0);
    run_burn(3'd4, 14'h1001, 8'h12, 5'b10110, 25, 1'b0);
    t_abort();
    run_burn(3'd0, 14'h0777, 8'h9e, 5'b01111, 5, 1'b0);
    finished = 1;
    report();
  end

endmodule